// File: doc/BRIEF.md
# Way-Based Cache Maintenance Controller

This block is the maintenance front end of a set-associative cache. Software drives it through a small synchronous register port. It can start whole-way operations: write back dirty lines, drop lines, or both, for every way selected by a bitmask. It can also run single-line operations on a physical address, and it can drain all outstanding maintenance with a sync write. The controller owns the valid, dirty and tag state of the cache. It walks that state one set per clock and announces each dirty line that must be written back on an event output, which the data path acts on.

The auxiliary control register picks the associativity and the way size. The block derives the mask of usable ways and the total capacity from it. Per-master data and instruction lockdown registers are held for the replacement logic. The refill path marks lines valid, dirty and tagged through a narrow fill input. Busy status is kept per way: each bit of a written way mask drops on its own as that way finishes. Dropping whole ways is refused while the cache is switched on.

Top module: `way_maint_ctrl`

## Requirements
- R1: Writing a way mask to a way-command register (word 4 = write back, 5 = drop, 6 = write back and drop) starts that operation on the selected usable ways when the controller is idle. The register reads back the remaining mask, and each way occupies SETS clock cycles, one set per clock.
- R2: The selected ways are processed one at a time in ascending index order. With write edge E0, the k-th selected way (counting from 0) reads 0 from edge E(k+1)*SETS onward.
- R3: A write-back operation emits one event (wb_valid with way and set) for each valid dirty line it visits and clears that line's dirty bit. A second write-back of the same ways emits nothing.
- R4: A drop operation clears valid and dirty without any event. Write back and drop emits events for the dirty lines and then leaves them invalid.
- R5: While control register word 0 bit 0 (enable) is 1, a write to word 5 is refused: no line changes, the register reads 0, and the error bit is set. Write-back by way still runs.
- R6: Any way or line command written while the controller is not idle is ignored and sets the error bit (word 2 bit 0). Any write to word 2 clears that bit.
- R7: A write of any value to word 3 sets bit 0 of that word. The bit falls one edge after the controller is idle, so it clears at E1 if written at E0 while idle, and it stays 1 until the clock edge after the last busy way has finished.
- R8: Words 8, 9 and 10 (write back, drop, both) take a byte address. The offset bits [4:0] are ignored, the set is taken from bits [8:5] and the tag from bits [16:9]. Only a valid line in that set with a matching tag is affected. Bit 0 of the word reads 1 for exactly one cycle after the write.
- R9: Word 1 bit 16 selects 16 usable ways when 1 and 8 when 0. The usable mask is (1 << ways) - 1, and way-command mask bits outside it are dropped. A mask that becomes empty starts nothing and raises no error.
- R10: The way size is 1 << (word 1 bits [19:17] + 3) KB, and cache_size_kb equals the number of ways times the way size. Word 1 reads back as written.
- R11: Eight lockdown pairs live at words 16 + 2m (data) and 17 + 2m (instruction) for master m. Each is readable and writable, and writing 0 clears every lock bit.
- R12: After reset, every register reads 0, no way or line is busy, all lines are invalid, and there are 8 usable ways with a 64 KB total size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, same cycle |
| fill_en | input | 1 | Refill marks a line valid |
| fill_way | input | 4 | Way of the refilled line |
| fill_set | input | 4 | Set of the refilled line |
| fill_tag | input | 8 | Tag of the refilled line |
| fill_dirty | input | 1 | Refilled line starts dirty |
| wb_valid | output | 1 | A dirty line is being written back this cycle |
| wb_way | output | 4 | Way of the written-back line |
| wb_set | output | 4 | Set of the written-back line |
| active_way_mask | output | 16 | Mask of usable ways |
| cache_size_kb | output | 32 | Total capacity in KB |

## Verification
The hardest situations to reach are the ones where a command arrives at the wrong moment. Examples are a drop-by-way while the enable bit is set, a way or line command while a walk is already running, and a sync written partway through a walk. In each case the cycle of arrival decides the outcome. The stimulus first seeds dirty lines through the fill input. It then issues the conflicting write a known number of cycles after the first command and samples the busy bits on both sides of the edges where they are meant to fall. Refused commands are shown to have had no effect by running a later write-back over the same lines and checking the scoreboard of expected write-back events.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_CLEAN = 2'd1,
      OP_INV   = 2'd2,
      OP_CINV  = 2'd3
   } mop_e;

   localparam int RI_CTRL  = 0;
   localparam int RI_AUX   = 1;
   localparam int RI_STAT  = 2;
   localparam int RI_SYNC  = 3;
   localparam int RI_WCLN  = 4;
   localparam int RI_WINV  = 5;
   localparam int RI_WCINV = 6;
   localparam int RI_LCLN  = 8;
   localparam int RI_LINV  = 9;
   localparam int RI_LCINV = 10;
   localparam int RI_LOCK0 = 16;

endpackage

// File: rtl/wmc_geom.sv
module wmc_geom #(
   parameter int MAX_WAYS  = 16,
   parameter int DW        = 32,
   parameter int WSZ_W     = 3,
   parameter int WSZ_SHIFT = 3
) (
   input  logic                ways16,
   input  logic [WSZ_W-1:0]    wsz_field,
   output logic [MAX_WAYS-1:0] active_mask,
   output logic [DW-1:0]       cache_kb
);

   logic [DW-1:0] way_kb;

   generate
      if (MAX_WAYS < 16) begin : g_bad_ways
         $error("wmc_geom: MAX_WAYS must be at least 16");
      end
      for (genvar w = 0; w < MAX_WAYS; w++) begin : g_mask
         if (w < 8) begin : g_low
            assign active_mask[w] = 1'b1;
         end else if (w < 16) begin : g_high
            assign active_mask[w] = ways16;
         end else begin : g_none
            assign active_mask[w] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      way_kb   = DW'(1) << (DW'(wsz_field) + DW'(WSZ_SHIFT));
      cache_kb = ways16 ? (way_kb << 4) : (way_kb << 3);
   end

endmodule

// File: rtl/wmc_walker.sv
module wmc_walker
   import wmc_pkg::*;
#(
   parameter int SETS     = 16,
   parameter int MAX_WAYS = 16,
   parameter int TAG_W    = 8,
   localparam int SET_W   = $clog2(SETS),
   localparam int WAY_W   = $clog2(MAX_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                way_start,
   input  mop_e                way_op,
   input  logic [MAX_WAYS-1:0] way_mask_in,
   input  logic                line_start,
   input  mop_e                line_op,
   input  logic [SET_W-1:0]    line_set,
   input  logic [TAG_W-1:0]    line_tag,
   input  logic                fill_en,
   input  logic [WAY_W-1:0]    fill_way,
   input  logic [SET_W-1:0]    fill_set,
   input  logic [TAG_W-1:0]    fill_tag,
   input  logic                fill_dirty,
   output logic                idle,
   output logic [MAX_WAYS-1:0] busy_mask,
   output mop_e                busy_op,
   output logic                line_busy,
   output mop_e                line_busy_op,
   output logic                wb_valid,
   output logic [WAY_W-1:0]    wb_way,
   output logic [SET_W-1:0]    wb_set
);

   typedef enum logic [1:0] {S_IDLE, S_WAY, S_LINE} wst_e;

   wst_e                st;
   logic [MAX_WAYS-1:0] mask_q;
   mop_e                op_q;
   logic [SET_W-1:0]    cnt;
   mop_e                lop_q;
   logic [SET_W-1:0]    lset_q;
   logic [TAG_W-1:0]    ltag_q;

   logic [MAX_WAYS-1:0] vld [SETS];
   logic [MAX_WAYS-1:0] drt [SETS];
   logic [TAG_W-1:0]    tg  [SETS][MAX_WAYS];

   logic [WAY_W-1:0]    cur_way;
   logic                hit;
   logic [WAY_W-1:0]    hit_way;
   logic                act_en;
   logic [WAY_W-1:0]    act_way;
   logic [SET_W-1:0]    act_set;
   mop_e                act_op;

   generate
      if (SETS < 2) begin : g_bad_sets
         $error("wmc_walker: SETS must be at least 2");
      end
   endgenerate

   function automatic logic [WAY_W-1:0] lowest(input logic [MAX_WAYS-1:0] m);
      logic [WAY_W-1:0] r;
      r = '0;
      for (int i = MAX_WAYS - 1; i >= 0; i--)
         if (m[i]) r = WAY_W'(i);
      return r;
   endfunction

   always_comb begin
      cur_way = lowest(mask_q);
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < MAX_WAYS; w++) begin
         if (!hit && vld[lset_q][w] && (tg[lset_q][w] == ltag_q)) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
      act_en  = 1'b0;
      act_way = cur_way;
      act_set = cnt;
      act_op  = op_q;
      if (st == S_WAY) begin
         act_en = 1'b1;
      end else if (st == S_LINE) begin
         act_en  = hit;
         act_way = hit_way;
         act_set = lset_q;
         act_op  = lop_q;
      end
   end

   assign wb_valid = act_en && act_op[0] && vld[act_set][act_way] && drt[act_set][act_way];
   assign wb_way   = act_way;
   assign wb_set   = act_set;

   // line state: refill marks, maintenance clears (maintenance wins)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld[s] <= '0;
            drt[s] <= '0;
         end
      end else begin
         if (fill_en) begin
            vld[fill_set][fill_way] <= 1'b1;
            drt[fill_set][fill_way] <= fill_dirty;
         end
         if (act_en) begin
            drt[act_set][act_way] <= 1'b0;
            if (act_op[1]) vld[act_set][act_way] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tg[fill_set][fill_way] <= fill_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         mask_q <= '0;
         op_q   <= OP_NONE;
         cnt    <= '0;
         lop_q  <= OP_NONE;
         lset_q <= '0;
         ltag_q <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (way_start) begin
                  mask_q <= way_mask_in;
                  op_q   <= way_op;
                  cnt    <= '0;
                  st     <= S_WAY;
               end else if (line_start) begin
                  lop_q  <= line_op;
                  lset_q <= line_set;
                  ltag_q <= line_tag;
                  st     <= S_LINE;
               end
            end
            S_WAY: begin
               if (cnt == SET_W'(SETS - 1)) begin
                  cnt             <= '0;
                  mask_q[cur_way] <= 1'b0;
                  if ((mask_q & ~(MAX_WAYS'(1) << cur_way)) == '0) st <= S_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign idle         = (st == S_IDLE);
   assign busy_mask    = mask_q;
   assign busy_op      = op_q;
   assign line_busy    = (st == S_LINE);
   assign line_busy_op = lop_q;

   // R1: busy bits never rise except on a fresh start
   a_r1_bits_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !way_start |=> ((mask_q & ~$past(mask_q)) == '0));

   // R2: ways finish one at a time
   a_r2_one_way_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q != '0) |=> ($countones($past(mask_q) & ~mask_q) <= 1));

   // R8: a single-line operation holds the engine one cycle
   a_r8_line_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      line_busy |=> !line_busy);

endmodule

// File: rtl/wmc_regs.sv
module wmc_regs
   import wmc_pkg::*;
#(
   parameter int REG_AW    = 6,
   parameter int DW        = 32,
   parameter int MAX_WAYS  = 16,
   parameter int N_MASTERS = 8,
   parameter int SET_W     = 4,
   parameter int TAG_W     = 8,
   parameter int LINE_OFF  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   input  logic [MAX_WAYS-1:0] active_mask,
   input  logic                idle,
   input  logic [MAX_WAYS-1:0] busy_mask,
   input  mop_e                busy_op,
   input  logic                line_busy,
   input  mop_e                line_busy_op,
   output logic                ctrl_en,
   output logic [DW-1:0]       aux,
   output logic                way_start,
   output mop_e                way_op,
   output logic [MAX_WAYS-1:0] way_mask,
   output logic                line_start,
   output mop_e                line_op,
   output logic [SET_W-1:0]    line_set,
   output logic [TAG_W-1:0]    line_tag
);

   localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(RI_CTRL);
   localparam logic [REG_AW-1:0] A_AUX   = REG_AW'(RI_AUX);
   localparam logic [REG_AW-1:0] A_STAT  = REG_AW'(RI_STAT);
   localparam logic [REG_AW-1:0] A_SYNC  = REG_AW'(RI_SYNC);
   localparam logic [REG_AW-1:0] A_WCLN  = REG_AW'(RI_WCLN);
   localparam logic [REG_AW-1:0] A_WINV  = REG_AW'(RI_WINV);
   localparam logic [REG_AW-1:0] A_WCINV = REG_AW'(RI_WCINV);
   localparam logic [REG_AW-1:0] A_LCLN  = REG_AW'(RI_LCLN);
   localparam logic [REG_AW-1:0] A_LINV  = REG_AW'(RI_LINV);
   localparam logic [REG_AW-1:0] A_LCINV = REG_AW'(RI_LCINV);

   generate
      if (MAX_WAYS > DW) begin : g_bad_dw
         $error("wmc_regs: way mask wider than data word");
      end
      if (RI_LOCK0 + 2 * N_MASTERS > (1 << REG_AW)) begin : g_bad_aw
         $error("wmc_regs: lockdown registers exceed address space");
      end
      if (LINE_OFF + SET_W + TAG_W > DW) begin : g_bad_addr
         $error("wmc_regs: line address fields exceed data word");
      end
   endgenerate

   logic                err_q;
   logic                sync_busy;
   logic                way_refuse;
   logic                err_set;
   mop_e                way_wr_op;
   mop_e                line_wr_op;
   logic [MAX_WAYS-1:0] lock_d_w [N_MASTERS];
   logic [MAX_WAYS-1:0] lock_i_w [N_MASTERS];

   always_comb begin
      way_wr_op  = OP_NONE;
      line_wr_op = OP_NONE;
      if (reg_we) begin
         case (reg_addr)
            A_WCLN:  way_wr_op  = OP_CLEAN;
            A_WINV:  way_wr_op  = OP_INV;
            A_WCINV: way_wr_op  = OP_CINV;
            A_LCLN:  line_wr_op = OP_CLEAN;
            A_LINV:  line_wr_op = OP_INV;
            A_LCINV: line_wr_op = OP_CINV;
            default: ;
         endcase
      end
   end

   assign way_mask   = reg_wdata[MAX_WAYS-1:0] & active_mask;
   assign way_refuse = !idle || ((way_wr_op == OP_INV) && ctrl_en);
   assign way_start  = (way_wr_op != OP_NONE) && !way_refuse && (way_mask != '0);
   assign way_op     = way_wr_op;
   assign line_start = (line_wr_op != OP_NONE) && idle;
   assign line_op    = line_wr_op;
   assign line_set   = reg_wdata[LINE_OFF +: SET_W];
   assign line_tag   = reg_wdata[LINE_OFF + SET_W +: TAG_W];
   assign err_set    = ((way_wr_op != OP_NONE) && way_refuse) ||
                       ((line_wr_op != OP_NONE) && !idle);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         aux       <= '0;
         err_q     <= 1'b0;
         sync_busy <= 1'b0;
      end else begin
         if (reg_we && reg_addr == A_CTRL) ctrl_en <= reg_wdata[0];
         if (reg_we && reg_addr == A_AUX)  aux     <= reg_wdata;
         if (err_set)                          err_q <= 1'b1;
         else if (reg_we && reg_addr == A_STAT) err_q <= 1'b0;
         if (reg_we && reg_addr == A_SYNC) sync_busy <= 1'b1;
         else if (idle)                    sync_busy <= 1'b0;
      end
   end

   generate
      for (genvar m = 0; m < N_MASTERS; m++) begin : g_lock
         logic [MAX_WAYS-1:0] d_q;
         logic [MAX_WAYS-1:0] i_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               d_q <= '0;
               i_q <= '0;
            end else if (reg_we) begin
               if (reg_addr == REG_AW'(RI_LOCK0 + 2 * m))     d_q <= reg_wdata[MAX_WAYS-1:0];
               if (reg_addr == REG_AW'(RI_LOCK0 + 2 * m + 1)) i_q <= reg_wdata[MAX_WAYS-1:0];
            end
         end
         assign lock_d_w[m] = d_q;
         assign lock_i_w[m] = i_q;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata[0] = ctrl_en;
         A_AUX:   reg_rdata    = aux;
         A_STAT:  reg_rdata[0] = err_q;
         A_SYNC:  reg_rdata[0] = sync_busy;
         A_WCLN:  if (busy_op == OP_CLEAN) reg_rdata[MAX_WAYS-1:0] = busy_mask;
         A_WINV:  if (busy_op == OP_INV)   reg_rdata[MAX_WAYS-1:0] = busy_mask;
         A_WCINV: if (busy_op == OP_CINV)  reg_rdata[MAX_WAYS-1:0] = busy_mask;
         A_LCLN:  reg_rdata[0] = line_busy && (line_busy_op == OP_CLEAN);
         A_LINV:  reg_rdata[0] = line_busy && (line_busy_op == OP_INV);
         A_LCINV: reg_rdata[0] = line_busy && (line_busy_op == OP_CINV);
         default: begin
            for (int m = 0; m < N_MASTERS; m++) begin
               if (reg_addr == REG_AW'(RI_LOCK0 + 2 * m))     reg_rdata[MAX_WAYS-1:0] = lock_d_w[m];
               if (reg_addr == REG_AW'(RI_LOCK0 + 2 * m + 1)) reg_rdata[MAX_WAYS-1:0] = lock_i_w[m];
            end
         end
      endcase
   end

   // R7: the drain flag cannot drop while a walk is still running
   a_r7_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_busy && !idle) |=> sync_busy);

   // R6: a refused command leaves the error flag raised next cycle
   a_r6_error_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> err_q);

endmodule

// File: rtl/way_maint_ctrl.sv
module way_maint_ctrl
   import wmc_pkg::*;
#(
   parameter int SETS       = 16,
   parameter int MAX_WAYS   = 16,
   parameter int TAG_W      = 8,
   parameter int DW         = 32,
   parameter int REG_AW     = 6,
   parameter int N_MASTERS  = 8,
   parameter int LINE_BYTES = 32,
   parameter int WAYS_BIT   = 16,
   parameter int WSZ_LSB    = 17,
   parameter int WSZ_W      = 3,
   parameter int WSZ_SHIFT  = 3,
   localparam int SET_W     = $clog2(SETS),
   localparam int WAY_W     = $clog2(MAX_WAYS),
   localparam int LINE_OFF  = $clog2(LINE_BYTES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   input  logic                fill_en,
   input  logic [WAY_W-1:0]    fill_way,
   input  logic [SET_W-1:0]    fill_set,
   input  logic [TAG_W-1:0]    fill_tag,
   input  logic                fill_dirty,
   output logic                wb_valid,
   output logic [WAY_W-1:0]    wb_way,
   output logic [SET_W-1:0]    wb_set,
   output logic [MAX_WAYS-1:0] active_way_mask,
   output logic [DW-1:0]       cache_size_kb
);

   logic                ctrl_en;
   logic [DW-1:0]       aux;
   logic                idle;
   logic [MAX_WAYS-1:0] busy_mask;
   mop_e                busy_op;
   logic                line_busy;
   mop_e                line_busy_op;
   logic                way_start;
   mop_e                way_op;
   logic [MAX_WAYS-1:0] way_mask;
   logic                line_start;
   mop_e                line_op;
   logic [SET_W-1:0]    line_set;
   logic [TAG_W-1:0]    line_tag;

   wmc_geom #(
      .MAX_WAYS(MAX_WAYS), .DW(DW), .WSZ_W(WSZ_W), .WSZ_SHIFT(WSZ_SHIFT)
   ) u_geom (
      .ways16      (aux[WAYS_BIT]),
      .wsz_field   (aux[WSZ_LSB +: WSZ_W]),
      .active_mask (active_way_mask),
      .cache_kb    (cache_size_kb)
   );

   wmc_regs #(
      .REG_AW(REG_AW), .DW(DW), .MAX_WAYS(MAX_WAYS), .N_MASTERS(N_MASTERS),
      .SET_W(SET_W), .TAG_W(TAG_W), .LINE_OFF(LINE_OFF)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_addr     (reg_addr),
      .reg_we       (reg_we),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .active_mask  (active_way_mask),
      .idle         (idle),
      .busy_mask    (busy_mask),
      .busy_op      (busy_op),
      .line_busy    (line_busy),
      .line_busy_op (line_busy_op),
      .ctrl_en      (ctrl_en),
      .aux          (aux),
      .way_start    (way_start),
      .way_op       (way_op),
      .way_mask     (way_mask),
      .line_start   (line_start),
      .line_op      (line_op),
      .line_set     (line_set),
      .line_tag     (line_tag)
   );

   wmc_walker #(
      .SETS(SETS), .MAX_WAYS(MAX_WAYS), .TAG_W(TAG_W)
   ) u_walker (
      .clk          (clk),
      .rst_n        (rst_n),
      .way_start    (way_start),
      .way_op       (way_op),
      .way_mask_in  (way_mask),
      .line_start   (line_start),
      .line_op      (line_op),
      .line_set     (line_set),
      .line_tag     (line_tag),
      .fill_en      (fill_en),
      .fill_way     (fill_way),
      .fill_set     (fill_set),
      .fill_tag     (fill_tag),
      .fill_dirty   (fill_dirty),
      .idle         (idle),
      .busy_mask    (busy_mask),
      .busy_op      (busy_op),
      .line_busy    (line_busy),
      .line_busy_op (line_busy_op),
      .wb_valid     (wb_valid),
      .wb_way       (wb_way),
      .wb_set       (wb_set)
   );

   // R5: no drop-by-way walk may begin with the cache switched on
   a_r5_inv_refused_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (way_start && way_op == OP_INV) |-> !ctrl_en);

   // R9: a walk only ever holds usable ways once started
   a_r9_walk_within_active: assert property (@(posedge clk) disable iff (!rst_n)
      way_start |=> ((busy_mask & ~$past(active_way_mask)) == '0));

endmodule

// File: tb/tb_way_maint_ctrl.sv
module tb_way_maint_ctrl;

   localparam int CLK_P  = 10;
   localparam int N_SETS = 16;

   localparam int W_CTRL = 0, W_AUX = 1, W_STAT = 2, W_SYNC = 3;
   localparam int W_WCLN = 4, W_WINV = 5, W_WCINV = 6;
   localparam int W_LCLN = 8, W_LINV = 9, W_LCINV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fill_en = 1'b0;
   logic [3:0]  fill_way = '0;
   logic [3:0]  fill_set = '0;
   logic [7:0]  fill_tag = '0;
   logic        fill_dirty = 1'b0;
   logic        wb_valid;
   logic [3:0]  wb_way;
   logic [3:0]  wb_set;
   logic [15:0] active_way_mask;
   logic [31:0] cache_size_kb;

   always #(CLK_P / 2) clk = ~clk;

   way_maint_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_en(fill_en),
      .fill_way(fill_way), .fill_set(fill_set), .fill_tag(fill_tag),
      .fill_dirty(fill_dirty), .wb_valid(wb_valid), .wb_way(wb_way),
      .wb_set(wb_set), .active_way_mask(active_way_mask),
      .cache_size_kb(cache_size_kb)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model of line state
   bit         m_v [16][16];
   bit         m_d [16][16];
   logic [7:0] m_t [16][16];
   logic [15:0] m_active = 16'h00FF;
   logic [7:0] exp_q [$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 6'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic fill(input int w, input int s, input logic [7:0] t, input bit dty);
      fill_en = 1'b1; fill_way = 4'(w); fill_set = 4'(s); fill_tag = t; fill_dirty = dty;
      @(negedge clk);
      fill_en = 1'b0;
      m_v[s][w] = 1'b1; m_d[s][w] = dty; m_t[s][w] = t;
   endtask

   // op: 1 write back, 2 drop, 3 both
   task automatic push_way(input int op, input logic [15:0] mask);
      logic [15:0] mk;
      mk = mask & m_active;
      for (int w = 0; w < 16; w++) begin
         if (mk[w]) begin
            for (int s = 0; s < N_SETS; s++) begin
               if ((op & 1) != 0 && m_v[s][w] && m_d[s][w]) exp_q.push_back({4'(w), 4'(s)});
               m_d[s][w] = 1'b0;
               if ((op & 2) != 0) m_v[s][w] = 1'b0;
            end
         end
      end
   endtask

   function automatic logic [31:0] laddr(input int s, input logic [7:0] t, input int off);
      return (32'(t) << 9) | (32'(s) << 5) | 32'(off);
   endfunction

   task automatic push_line(input int op, input logic [31:0] a);
      int s;
      logic [7:0] t;
      bit found;
      s = int'(a[8:5]); t = a[16:9]; found = 1'b0;
      for (int w = 0; w < 16; w++) begin
         if (!found && m_v[s][w] && m_t[s][w] == t) begin
            found = 1'b1;
            if ((op & 1) != 0 && m_d[s][w]) exp_q.push_back({4'(w), 4'(s)});
            m_d[s][w] = 1'b0;
            if ((op & 2) != 0) m_v[s][w] = 1'b0;
         end
      end
   endtask

   task automatic drained(input string req);
      chk(req, 32'(exp_q.size()), 32'd0);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && wb_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R3 unexpected write-back actual=%h expected=none", {wb_way, wb_set});
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if ({wb_way, wb_set} !== e) begin
               fails++;
               $display("FAIL R3 write-back actual=%h expected=%h", {wb_way, wb_set}, e);
            end
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] la;
      for (int s = 0; s < 16; s++)
         for (int w = 0; w < 16; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; end
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R12 reset state
      rd(W_CTRL, v); chk("R12 ctrl", v, 0);
      rd(W_AUX, v);  chk("R12 aux", v, 0);
      rd(W_STAT, v); chk("R12 status", v, 0);
      rd(W_SYNC, v); chk("R12 sync", v, 0);
      rd(W_WCLN, v); chk("R12 way busy", v, 0);
      rd(W_LCLN, v); chk("R12 line busy", v, 0);
      rd(30, v);     chk("R12 lockdown", v, 0);
      chk("R12 usable ways", 32'(active_way_mask), 32'h00FF);
      chk("R12 size", cache_size_kb, 32'd64);
      push_way(1, 16'hFFFF);
      wr(W_WCLN, 32'hFF); cyc(8 * N_SETS + 1);
      drained("R12 all invalid");

      // R1 R2 R3 per-way busy, order, write-back
      fill(1, 2, 8'h10, 1); fill(3, 7, 8'h11, 1); fill(3, 0, 8'h12, 1); fill(1, 15, 8'h13, 0);
      push_way(1, 16'h000A);
      wr(W_WCLN, 32'h0A);
      rd(W_WCLN, v); chk("R1 mask readback", v, 32'h0A);
      rd(W_WINV, v); chk("R1 other reg idle", v, 0);
      cyc(N_SETS - 1); rd(W_WCLN, v); chk("R2 first way still busy", v, 32'h0A);
      cyc(1);          rd(W_WCLN, v); chk("R2 lowest way first", v, 32'h08);
      cyc(N_SETS);     rd(W_WCLN, v); chk("R1 all ways done", v, 0);
      drained("R3 write-backs");
      push_way(1, 16'h000A);
      wr(W_WCLN, 32'h0A); cyc(2 * N_SETS + 1);
      drained("R3 second clean silent");

      // R4 drop and write-back-and-drop
      fill(2, 5, 8'h20, 1);
      push_way(2, 16'h0004);
      wr(W_WINV, 32'h04); cyc(N_SETS + 1);
      push_way(1, 16'h0004);
      wr(W_WCLN, 32'h04); cyc(N_SETS + 1);
      drained("R4 drop leaves nothing");
      fill(2, 6, 8'h21, 1); fill(2, 9, 8'h22, 1);
      push_way(3, 16'h0004);
      wr(W_WCINV, 32'h04); cyc(N_SETS + 1);
      drained("R4 both writes back");
      push_way(1, 16'h0004);
      wr(W_WCLN, 32'h04); cyc(N_SETS + 1);
      drained("R4 both invalidates");

      // R5 drop refused while enabled
      wr(W_CTRL, 1);
      fill(0, 0, 8'h30, 1);
      wr(W_WINV, 32'h01);
      rd(W_WINV, v); chk("R5 refused not busy", v, 0);
      rd(W_STAT, v); chk("R5 error set", v, 1);
      push_way(1, 16'h0001);
      wr(W_WCLN, 32'h01); cyc(N_SETS + 1);
      drained("R5 line survived");
      wr(W_CTRL, 0);
      wr(W_STAT, 0);
      rd(W_STAT, v); chk("R6 error cleared", v, 0);

      // R6 commands while busy
      fill(4, 9, 8'h33, 1);
      push_way(1, 16'h0001);
      wr(W_WCLN, 32'h01);
      wr(W_WINV, 32'h02);
      rd(W_WCLN, v); chk("R6 walk unaffected", v, 32'h01);
      rd(W_STAT, v); chk("R6 way cmd busy error", v, 1);
      wr(W_STAT, 0);
      wr(W_LCLN, laddr(9, 8'h33, 0));
      rd(W_STAT, v); chk("R6 line cmd busy error", v, 1);
      cyc(N_SETS);
      drained("R6 ignored line cmd");
      wr(W_STAT, 0);
      la = laddr(9, 8'h33, 0);
      push_line(1, la);
      wr(W_LCLN, la); cyc(2);
      drained("R6 line cmd later accepted");

      // R7 sync
      wr(W_SYNC, 32'hDEAD_BEEF);
      rd(W_SYNC, v); chk("R7 sync busy idle", v, 1);
      cyc(1); rd(W_SYNC, v); chk("R7 sync clears", v, 0);
      push_way(1, 16'h0001);
      wr(W_WCLN, 32'h01);
      wr(W_SYNC, 0);
      rd(W_SYNC, v); chk("R7 sync waits", v, 1);
      cyc(N_SETS - 1); rd(W_SYNC, v); chk("R7 sync held at last way", v, 1);
      rd(W_WCLN, v); chk("R7 walk done", v, 0);
      cyc(1); rd(W_SYNC, v); chk("R7 sync drained", v, 0);

      // R8 line ops
      fill(5, 3, 8'h2A, 1);
      la = laddr(3, 8'h2A, 31);
      push_line(1, la);
      wr(W_LCLN, la);
      rd(W_LCLN, v); chk("R8 line busy", v, 1);
      cyc(1); rd(W_LCLN, v); chk("R8 line busy one cycle", v, 0);
      drained("R8 unaligned hit");
      fill(6, 3, 8'h11, 1);
      la = laddr(3, 8'h12, 4);
      push_line(3, la);
      wr(W_LCINV, la); cyc(2);
      drained("R8 tag miss silent");
      la = laddr(3, 8'h11, 0);
      push_line(3, la);
      wr(W_LCINV, la); cyc(2);
      drained("R8 tag hit");
      push_way(1, 16'h0040);
      wr(W_WCLN, 32'h40); cyc(N_SETS + 1);
      drained("R8 line dropped");

      // R9 usable ways
      fill(8, 1, 8'h40, 1);
      wr(W_WCLN, 32'h100);
      rd(W_WCLN, v); chk("R9 masked way not started", v, 0);
      rd(W_STAT, v); chk("R9 empty mask no error", v, 0);
      cyc(2); drained("R9 no write-back in 8-way mode");
      wr(W_AUX, 32'h0001_0000);
      m_active = 16'hFFFF;
      chk("R9 16-way mask", 32'(active_way_mask), 32'hFFFF);
      push_way(1, 16'h0100);
      wr(W_WCLN, 32'h100);
      rd(W_WCLN, v); chk("R9 upper way busy", v, 32'h100);
      cyc(N_SETS); drained("R9 upper way cleaned");

      // R10 size
      chk("R10 16 ways field 0", cache_size_kb, 32'd128);
      wr(W_AUX, 32'h0001_0000 | (32'd3 << 17));
      chk("R10 16 ways field 3", cache_size_kb, 32'd1024);
      rd(W_AUX, v); chk("R10 aux readback", v, 32'h0007_0000);
      wr(W_AUX, 32'd5 << 17);
      m_active = 16'h00FF;
      chk("R10 8 ways field 5", cache_size_kb, 32'd2048);
      chk("R9 back to 8 ways", 32'(active_way_mask), 32'h00FF);

      // R11 lockdown
      wr(30, 32'h00F0); wr(21, 32'h0003);
      rd(30, v); chk("R11 data lock m7", v, 32'h00F0);
      rd(21, v); chk("R11 instr lock m2", v, 32'h0003);
      rd(16, v); chk("R11 other master", v, 0);
      wr(30, 0); wr(21, 0);
      rd(30, v); chk("R11 unlock data", v, 0);
      rd(21, v); chk("R11 unlock instr", v, 0);

      cyc(2);
      drained("R3 final queue");
      finish_run();
   end

endmodule